// File: doc/BRIEF.md
# Windowed wrapping address generator

This block produces the successive word addresses for one side of a DMA transfer. A load strobe captures a base pointer and a 3-bit wrap code. Each advance strobe then moves the output address forward by one 32-bit word. The output address is always the base plus a word offset.

When the wrap code is nonzero, the offset counts modulo a power-of-two window. The address therefore cycles over a fixed region, such as a peripheral FIFO or a ring buffer. A wrap code of zero gives a plain linear increment.

The `SIDE` parameter selects one of two window sets. The memory side offers windows from 32 to 2048 words. The peripheral side offers windows from 1 to 64 words. A restart strobe returns the offset to zero for repeat-block operation and keeps the captured base and window.

Top module: `wrap_addr_gen`

## Requirements
- R1: After reset, `addr_o` is zero and no wrap window is active.
- R2: One cycle after `load_i`, `addr_o` equals the new base and the word offset is zero.
- R3: Bits 1:0 of `addr_o` are always zero; bits 1:0 of `base_i` are ignored.
- R4: With wrap code 0, each accepted advance raises `addr_o` by 4 (one word), modulo the address width.
- R5: On the memory side (`SIDE` = SIDE_MEM), wrap code k in 1..7 selects a window of 2^(k+4) words (32 to 2048). After that many advances, the address is back at the base.
- R6: On the peripheral side (`SIDE` = SIDE_PER), wrap code k in 1..7 selects a window of 2^(k-1) words (1 to 64). Code 1 holds the address fixed at the base.
- R7: A base that is not aligned to the window still works. After n advances the address is base + 4*(n mod window).
- R8: An advance in the same cycle as a load is ignored; the address after that cycle is the new base.
- R9: `restart_i` returns the offset to zero and keeps the captured base and wrap code. `load_i` takes priority over `restart_i`, and an advance in the same cycle as a restart is ignored.
- R10: With no strobe asserted, `addr_o` holds its value. A change on `base_i` or `wrap_i` without `load_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture base and wrap code, clear offset |
| base_i | input | ADDR_W | Base byte address (low two bits ignored) |
| wrap_i | input | 3 | Encoded wrap window, 0 = linear |
| restart_i | input | 1 | Block restart: clear offset |
| adv_i | input | 1 | Advance one word |
| addr_o | output | ADDR_W | Current word-aligned address |

## Verification
The bench checks three wrap boundaries on both sides: the smallest memory window, a middle window, and the 2048-word window at its final step. A mask that is off by one bit would wrap early or late there, and the address would drift past the window end.

It also checks the one-word peripheral window, which must never move. It checks a base that is not aligned to its window. A design that ORs the offset into the base instead of adding it would give wrong addresses in that case.

Strobe collisions are checked as well: load with advance, restart with load, and restart with advance. A wrong priority would leave the address one word past the base, or on the old base.

// File: rtl/wag_pkg.sv
package wag_pkg;
  localparam int unsigned WRAP_W = 3;

  typedef enum logic {SIDE_MEM = 1'b0, SIDE_PER = 1'b1} side_e;

  typedef logic [WRAP_W-1:0] wrap_code_t;
endpackage

// File: rtl/wag_decode.sv
module wag_decode
  import wag_pkg::*;
#(
  parameter int unsigned OFF_W = 30,
  parameter side_e       SIDE  = SIDE_MEM
) (
  input  wrap_code_t       code_i,
  output logic [OFF_W-1:0] mask_o
);
  logic [3:0] lg;

  // log2 of the window in words for each side
  generate
    if (SIDE == SIDE_MEM) begin : g_mem
      assign lg = {1'b0, code_i} + 4'd4;
    end else begin : g_per
      assign lg = {1'b0, code_i} - 4'd1;
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < int'(OFF_W); i++) begin
      mask_o[i] = (code_i == '0) || (int'(lg) > i);
    end
  end
endmodule

// File: rtl/wag_offset.sv
module wag_offset #(
  parameter int unsigned OFF_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [OFF_W-1:0] mask_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
    end else if (clr_i) begin
      off_q <= '0;
    end else if (adv_i) begin
      off_q <= (off_q + 1'b1) & mask_i;
    end
  end

  assign off_o = off_q;
endmodule

// File: rtl/wag_sum.sv
module wag_sum #(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned OFF_W = ADDR_W - 2
) (
  input  logic [OFF_W-1:0]  base_w_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  // offset is added, not ORed, so unaligned bases stay correct
  assign addr_o = {base_w_i + off_i, 2'b00};
endmodule

// File: rtl/wrap_addr_gen.sv
module wrap_addr_gen
  import wag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter side_e       SIDE   = SIDE_MEM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [WRAP_W-1:0] wrap_i,
  input  logic              restart_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned OFF_W = ADDR_W - 2;

  logic [OFF_W-1:0] base_q;
  wrap_code_t       code_q;
  logic [OFF_W-1:0] mask_q;
  logic [OFF_W-1:0] off_q;
  logic             clr;
  logic             adv_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      code_q <= '0;
    end else if (load_i) begin
      base_q <= base_i[ADDR_W-1:2];
      code_q <= wrap_i;
    end
  end

  assign clr    = load_i | restart_i;
  assign adv_ok = adv_i & ~clr;

  wag_decode #(.OFF_W(OFF_W), .SIDE(SIDE)) u_decode (
    .code_i (code_q),
    .mask_o (mask_q)
  );

  wag_offset #(.OFF_W(OFF_W)) u_offset (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (adv_ok),
    .mask_i (mask_q),
    .off_o  (off_q)
  );

  wag_sum #(.ADDR_W(ADDR_W)) u_sum (
    .base_w_i (base_q),
    .off_i    (off_q),
    .addr_o   (addr_o)
  );
endmodule

// File: rtl/wag_checker.sv
module wag_checker
  import wag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter side_e       SIDE   = SIDE_MEM,
  localparam int unsigned OFF_W = ADDR_W - 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              restart_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [OFF_W-1:0]  base_q,
  input logic [WRAP_W-1:0] code_q,
  input logic [OFF_W-1:0]  off_q,
  input logic [OFF_W-1:0]  mask_q
);
  AST_LOAD_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == {$past(base_i[ADDR_W-1:2]), 2'b00}); // R2

  AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[1:0] == 2'b00); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !restart_i && code_q == '0) |=> addr_o == $past(addr_o) + ADDR_W'(4)); // R4

  AST_OFF_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_q & ~mask_q) == '0); // R5

  AST_FIXED_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SIDE == SIDE_PER && code_q == 3'd1 && !load_i && !restart_i) |=> $stable(addr_o)); // R6

  AST_RESTART_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !load_i) |=> addr_o == {$past(base_q), 2'b00}); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !restart_i && !adv_i) |=> $stable(addr_o)); // R10
endmodule

bind wrap_addr_gen wag_checker #(.ADDR_W(ADDR_W), .SIDE(SIDE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .restart_i (restart_i),
  .adv_i     (adv_i),
  .base_i    (base_i),
  .addr_o    (addr_o),
  .base_q    (base_q),
  .code_q    (code_q),
  .off_q     (off_q),
  .mask_q    (mask_q)
);

// File: tb/wrap_addr_gen_bench.sv
`timescale 1ns/1ps
module wrap_addr_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [2:0]  wm_i = '0;
  logic [2:0]  wp_i = '0;
  logic        restart_i = 1'b0;
  logic        adv_i = 1'b0;
  logic [31:0] addr_m;
  logic [31:0] addr_p;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [29:0] base_w = '0;
  int cm = 0, cp = 0;
  logic [29:0] om = '0, op = '0;

  always #2.5 clk_i = ~clk_i;

  wrap_addr_gen #(.ADDR_W(32), .SIDE(wag_pkg::SIDE_MEM)) u_wrap_addr_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .base_i(base_i), .wrap_i(wm_i),
    .restart_i(restart_i), .adv_i(adv_i), .addr_o(addr_m));

  wrap_addr_gen #(.ADDR_W(32), .SIDE(wag_pkg::SIDE_PER)) u_wrap_addr_gen_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .base_i(base_i), .wrap_i(wp_i),
    .restart_i(restart_i), .adv_i(adv_i), .addr_o(addr_p));

  function automatic int win(input int side, input int code);
    if (code == 0) return 0;
    return (side == 0) ? (1 << (code + 4)) : (1 << (code - 1));
  endfunction

  function automatic logic [29:0] bump(input logic [29:0] o, input int w);
    if (w == 0) return o + 30'd1;
    return 30'((int'(o) + 1) % w);
  endfunction

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input string tag);
    logic [31:0] em, ep;
    em = {base_w + om, 2'b00};
    ep = {base_w + op, 2'b00};
    checks += 2;
    if (addr_m !== em) begin
      errors++;
      $display("FAIL %s mem side: addr %h expected %h", tag, addr_m, em);
    end
    if (addr_p !== ep) begin
      errors++;
      $display("FAIL %s per side: addr %h expected %h", tag, addr_p, ep);
    end
  endtask

  // drive at negedge, clock once, update the model, check at the next negedge
  task automatic step(input bit ld, input logic [31:0] b, input logic [2:0] wm, input logic [2:0] wp,
                      input bit rs, input bit av, input string tag);
    load_i = ld; base_i = b; wm_i = wm; wp_i = wp; restart_i = rs; adv_i = av;
    @(posedge clk_i);
    @(negedge clk_i);
    load_i = 1'b0; restart_i = 1'b0; adv_i = 1'b0;
    if (ld) begin
      base_w = b[31:2]; cm = int'(wm); cp = int'(wp); om = '0; op = '0;
    end else if (rs) begin
      om = '0; op = '0;
    end else if (av) begin
      om = bump(om, win(0, cm));
      op = bump(op, win(1, cp));
    end
    check(tag);
  endtask

  task automatic t_reset();
    check("R1");
  endtask

  task automatic t_linear();
    step(1, 32'h0000_1003, 3'd0, 3'd0, 0, 0, "R2 R3");
    for (int i = 0; i < 6; i++) step(0, 32'h0000_1003, 3'd0, 3'd0, 0, 1, "R4");
  endtask

  task automatic t_windows(input logic [2:0] code);
    step(1, 32'h4000_0000, code, code, 0, 0, "R2");
    for (int i = 0; i < win(0, int'(code)) + 3; i++)
      step(0, 32'h4000_0000, code, code, 0, 1, "R5 R6");
  endtask

  task automatic t_per_fixed();
    step(1, 32'h0000_0a40, 3'd0, 3'd1, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(0, 32'h0000_0a40, 3'd0, 3'd1, 0, 1, "R6");
  endtask

  task automatic t_unaligned();
    step(1, 32'h0000_2010, 3'd1, 3'd3, 0, 0, "R7");
    for (int i = 0; i < 40; i++) step(0, 32'h0000_2010, 3'd1, 3'd3, 0, 1, "R7");
  endtask

  task automatic t_load_adv();
    step(0, 32'h0, 3'd0, 3'd0, 0, 1, "R8");
    step(1, 32'h0000_3000, 3'd2, 3'd4, 0, 1, "R8");
  endtask

  task automatic t_restart();
    step(1, 32'h0000_0800, 3'd2, 3'd4, 0, 0, "R9");
    for (int i = 0; i < 5; i++) step(0, 32'h0, 3'd0, 3'd0, 0, 1, "R9");
    step(0, 32'h0, 3'd0, 3'd0, 1, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, 32'h0, 3'd0, 3'd0, 0, 1, "R9");
    step(0, 32'h0, 3'd0, 3'd0, 1, 1, "R9");
    step(0, 32'h0, 3'd0, 3'd0, 0, 1, "R9");
    step(1, 32'h0000_5500, 3'd1, 3'd2, 1, 0, "R9");
    step(0, 32'h0, 3'd0, 3'd0, 0, 1, "R9");
  endtask

  task automatic t_idle();
    step(0, 32'h0, 3'd0, 3'd0, 0, 1, "R10");
    for (int i = 0; i < 4; i++) step(0, 32'hdead_beef, 3'd7, 3'd7, 0, 0, "R10");
    step(0, 32'h0, 3'd0, 3'd0, 0, 1, "R10");
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_linear();
    t_windows(3'd1);
    t_windows(3'd3);
    t_windows(3'd7);
    t_per_fixed();
    t_unaligned();
    t_load_adv();
    t_restart();
    t_idle();
    report();
    $finish;
  end
endmodule